// File: doc/BRIEF.md
# Single-descriptor DMA channel with error freeze

This block is one DMA channel that runs a single buffer descriptor at a time. A descriptor gives a source address, a destination address, a byte count and two hold flags. Each hold flag pins one side's address for the whole transfer, so a single source word can be copied across a region, or a region can be streamed into a single destination. The channel moves one data word per beat. It first reads the word on the read port, then writes it on the write port. Each port uses a plain request/acknowledge handshake, and the acknowledge can carry a bus-error flag.

Errors go into a small error register that several channels would share. Bit 0 records a read-port error, bit 1 a write-port error and bit 2 a zero-length descriptor. A port error freezes the channel: it stops issuing requests and keeps its busy flag. A zero-length descriptor also leaves the busy flag set and issues no requests. This lets software find the offending channel from its busy flag, since the error bit does not name the channel. The only way out of a frozen or stuck channel is a restart write to the control register. Clearing error bits does not restart the channel.

Top module: `dma_freeze_channel`

## Requirements
- R1: After reset, chan_active, chan_frozen, rd_req, wr_req and all err_flags bits are 0.
- R2: A desc_load accepted while the channel is idle sets chan_active one cycle later. A non-zero size runs size/4 beats. Each beat is one accepted read followed by one write, the two requests are never high together, and each write carries the data returned by that beat's read.
- R3: On a side whose hold flag is 0, the address of beat i is the descriptor address plus 4*i (32-bit data, 4-byte beats).
- R4: On a side whose hold flag is 1, every beat uses the descriptor address. The source and destination hold flags act independently.
- R5: After the last write is acknowledged without error, chan_active returns to 0 and err_flags is unchanged.
- R6: A read acknowledge with rd_err sets err_flags bit 0, and a write acknowledge with wr_err sets bit 1. In either case chan_frozen becomes 1, chan_active stays 1, and no further request is issued.
- R7: A write to register 0 clears every err_flags bit whose reg_wr_data bit is 1. It does not change chan_frozen or chan_active, and it does not restart requests.
- R8: A write to register 1 with reg_wr_data bit 0 set returns the channel to idle (chan_active 0, chan_frozen 0) and leaves err_flags unchanged. A new descriptor is then accepted.
- R9: A descriptor with size 0 sets err_flags bit 2 and leaves chan_active at 1. It does not set chan_frozen, and it issues no request until a restart.
- R10: A desc_load while chan_active or chan_frozen is 1 has no effect on the addresses, data or beat count of the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Descriptor load strobe |
| desc_src | input | ADDR_W | Descriptor source address |
| desc_dst | input | ADDR_W | Descriptor destination address |
| desc_size | input | CNT_W | Descriptor byte count |
| desc_src_hold | input | 1 | Keep the source address fixed |
| desc_dst_hold | input | 1 | Keep the destination address fixed |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | 0 = error register (write 1 to clear), 1 = control |
| reg_wr_data | input | 3 | Write data; on control, bit 0 requests a restart |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge |
| rd_err | input | 1 | Read bus error, qualified by rd_ack |
| rd_data | input | DATA_W | Read data, qualified by rd_ack |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write bus error, qualified by wr_ack |
| chan_active | output | 1 | Channel busy flag |
| chan_frozen | output | 1 | Channel frozen by a port error |
| err_flags | output | 3 | Shared error register |

## Verification
A wrong address-step decision shows up on rd_addr or wr_addr at the second beat. A wrong data capture shows up on wr_data in the first write. A wrong state after an error shows up within one cycle, as a request that should be absent or as chan_frozen and chan_active holding the wrong values. A lost or stray error bit is visible on err_flags in the cycle after the acknowledge or register write. Descriptor loads issued mid-transfer and while frozen are checked by comparing the full list of writes against the first descriptor.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        CH_IDLE   = 3'd0,
        CH_READ   = 3'd1,
        CH_WRITE  = 3'd2,
        CH_FROZEN = 3'd3,
        CH_STUCK  = 3'd4
    } ch_state_e;

    localparam int ERR_W      = 3;
    localparam int ERR_RD_BIT = 0;
    localparam int ERR_WR_BIT = 1;
    localparam int ERR_ZS_BIT = 2;

    localparam logic REG_ERR  = 1'b0;
    localparam logic REG_CTRL = 1'b1;
    localparam int   CTRL_RESTART_BIT = 0;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        addr_o = hold_i ? addr_i : addr_i + STEP_V;
    end
endmodule

// File: rtl/dma_err_reg.sv
module dma_err_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] err_o
);
    logic [N-1:0] err_d, err_q;

    always_comb begin
        // a new error wins over a clear in the same cycle
        err_d = (err_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    assign err_o = err_q;
endmodule

// File: rtl/dma_freeze_channel.sv
module dma_freeze_channel
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_load,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [CNT_W-1:0]  desc_size,
    input  logic              desc_src_hold,
    input  logic              desc_dst_hold,
    input  logic              reg_wr_en,
    input  logic              reg_wr_addr,
    input  logic [2:0]        reg_wr_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              chan_active,
    output logic              chan_frozen,
    output logic [2:0]        err_flags
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam logic [CNT_W-1:0] BEAT_CNT = CNT_W'(BEAT_BYTES);

    typedef struct packed {
        ch_state_e         st;
        logic              active;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              src_hold;
        logic              dst_hold;
        logic [DATA_W-1:0] word;
    } ch_t;

    ch_t q, d;
    logic [ERR_W-1:0]  err_set, err_clr;
    logic [ADDR_W-1:0] src_next, dst_next;
    logic              restart;
    logic              src_hold_now;

    assign restart = reg_wr_en && (reg_wr_addr == REG_CTRL)
                     && reg_wr_data[CTRL_RESTART_BIT];
    assign err_clr = (reg_wr_en && reg_wr_addr == REG_ERR) ? reg_wr_data : '0;
    assign src_hold_now = q.src_hold;

    dma_addr_step #(.ADDR_W(ADDR_W), .STEP(BEAT_BYTES)) u_src_step (
        .addr_i(q.src), .hold_i(q.src_hold), .addr_o(src_next)
    );
    dma_addr_step #(.ADDR_W(ADDR_W), .STEP(BEAT_BYTES)) u_dst_step (
        .addr_i(q.dst), .hold_i(q.dst_hold), .addr_o(dst_next)
    );

    always_comb begin
        d       = q;
        err_set = '0;
        unique case (q.st)
            CH_IDLE: begin
                if (desc_load) begin
                    d.active   = 1'b1;
                    d.src      = desc_src;
                    d.dst      = desc_dst;
                    d.cnt      = desc_size;
                    d.src_hold = desc_src_hold;
                    d.dst_hold = desc_dst_hold;
                    if (desc_size == '0) begin
                        err_set[ERR_ZS_BIT] = 1'b1;
                        d.st = CH_STUCK;
                    end else begin
                        d.st = CH_READ;
                    end
                end
            end
            CH_READ: begin
                if (rd_ack) begin
                    if (rd_err) begin
                        err_set[ERR_RD_BIT] = 1'b1;
                        d.st = CH_FROZEN;
                    end else begin
                        d.word = rd_data;
                        d.st   = CH_WRITE;
                    end
                end
            end
            CH_WRITE: begin
                if (wr_ack) begin
                    if (wr_err) begin
                        err_set[ERR_WR_BIT] = 1'b1;
                        d.st = CH_FROZEN;
                    end else begin
                        d.src = src_next;
                        d.dst = dst_next;
                        if (q.cnt <= BEAT_CNT) begin
                            d.cnt    = '0;
                            d.active = 1'b0;
                            d.st     = CH_IDLE;
                        end else begin
                            d.cnt = q.cnt - BEAT_CNT;
                            d.st  = CH_READ;
                        end
                    end
                end
            end
            default: ;  // frozen or stuck: wait for a restart
        endcase
        if (restart) begin
            d.st     = CH_IDLE;
            d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: CH_IDLE, active: 1'b0, src: '0, dst: '0, cnt: '0,
                   src_hold: 1'b0, dst_hold: 1'b0, word: '0};
        end else begin
            q <= d;
        end
    end

    dma_err_reg #(.N(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_i(err_clr), .err_o(err_flags)
    );

    assign rd_req      = (q.st == CH_READ);
    assign rd_addr     = q.src;
    assign wr_req      = (q.st == CH_WRITE);
    assign wr_addr     = q.dst;
    assign wr_data     = q.word;
    assign chan_active = q.active;
    assign chan_frozen = (q.st == CH_FROZEN);
endmodule

// File: rtl/dma_freeze_channel_chk.sv
module dma_freeze_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_load,
    input logic [CNT_W-1:0]  desc_size,
    input logic              reg_wr_en,
    input logic              reg_wr_addr,
    input logic [2:0]        reg_wr_data,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              rd_err,
    input logic              wr_req,
    input logic              wr_ack,
    input logic              wr_err,
    input logic              chan_active,
    input logic              chan_frozen,
    input logic [2:0]        err_flags,
    input logic              src_hold_now
);
    logic              restart;
    logic              seen_rd;
    logic [ADDR_W-1:0] last_rd;

    assign restart = reg_wr_en && reg_wr_addr && reg_wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_rd <= 1'b0;
            last_rd <= '0;
        end else if (!chan_active) begin
            seen_rd <= 1'b0;
        end else if (rd_req && rd_ack && !rd_err) begin
            seen_rd <= 1'b1;
            last_rd <= rd_addr;
        end
    end

    p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    p_src_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && src_hold_now && seen_rd |-> rd_addr == last_rd);

    p_rd_err_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_ack && rd_err && !restart |=> chan_frozen && chan_active && err_flags[0]);

    p_wr_err_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && wr_ack && wr_err && !restart |=> chan_frozen && chan_active && err_flags[1]);

    p_frozen_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_frozen |-> !rd_req && !wr_req);

    p_frozen_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_frozen && !restart |=> chan_frozen);

    p_restart_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !chan_active && !chan_frozen);

    p_zero_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load && !chan_active && !chan_frozen && desc_size == '0 && !restart
        |=> err_flags[2] && chan_active && !chan_frozen);

    p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load && chan_active && !rd_req && !wr_req && !restart
        |=> !rd_req && !wr_req);
endmodule

bind dma_freeze_channel dma_freeze_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_size(desc_size),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err),
    .wr_req(wr_req), .wr_ack(wr_ack), .wr_err(wr_err),
    .chan_active(chan_active), .chan_frozen(chan_frozen), .err_flags(err_flags),
    .src_hold_now(src_hold_now)
);

// File: tb/tb_dma_freeze_channel.sv
`timescale 1ns/1ps
module tb_dma_freeze_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [31:0] desc_src = '0, desc_dst = '0;
    logic [15:0] desc_size = '0;
    logic        desc_src_hold = 1'b0, desc_dst_hold = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_addr = 1'b0;
    logic [2:0]  reg_wr_data = '0;
    logic        rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;
    logic        chan_active, chan_frozen;
    logic [2:0]  err_flags;

    always #2 clk = ~clk;

    dma_freeze_channel dut (.*);

    int errors = 0, checks = 0;
    int nr = 0, nw = 0;
    int rd_err_beat = -1, wr_err_beat = -1;
    logic [31:0] rlog [64];
    logic [31:0] wlog_a [64];
    logic [31:0] wlog_d [64];

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h1234_5678;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            rd_ack  = rd_req && ($urandom_range(3) != 0);
            rd_err  = rd_ack && (rd_err_beat == nr);
            rd_data = memf(rd_addr);
            if (rd_ack && !rd_err && nr < 64) begin rlog[nr] = rd_addr; nr++; end
            wr_ack  = wr_req && ($urandom_range(3) != 0);
            wr_err  = wr_ack && (wr_err_beat == nw);
            if (wr_ack && !wr_err && nw < 64) begin
                wlog_a[nw] = wr_addr; wlog_d[nw] = wr_data; nw++;
            end
        end
    end

    task automatic reg_write(input logic a, input logic [2:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] dd, input logic [15:0] sz,
                        input bit sh, input bit dh);
        @(negedge clk);
        desc_src = s; desc_dst = dd; desc_size = sz;
        desc_src_hold = sh; desc_dst_hold = dh; desc_load = 1'b1;
        @(negedge clk);
        desc_load = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 3000; i++) begin
            if (!chan_active || chan_frozen) return;
            @(negedge clk);
        end
        check(1'b0, "R2", "transfer timeout", 0, 1);
    endtask

    task automatic run_xfer(input logic [31:0] s, input logic [31:0] dd, input int beats,
                            input bit sh, input bit dh, input bit poke);
        nr = 0; nw = 0;
        load(s, dd, 16'(beats * 4), sh, dh);
        check(chan_active === 1'b1, "R2", "active after load", chan_active, 1);
        if (poke) begin
            @(negedge clk);
            desc_src = 32'hDEAD_0000; desc_dst = 32'hBEEF_0000; desc_size = 16'd4;
            desc_load = 1'b1;
            @(negedge clk);
            desc_load = 1'b0;
        end
        wait_end();
        check(nw == beats, poke ? "R10" : "R2", "beat count", 64'(nw), 64'(beats));
        for (int i = 0; i < beats && i < nw; i++) begin
            logic [31:0] ea_s, ea_d;
            ea_s = sh ? s : s + 32'(i * 4);
            ea_d = dh ? dd : dd + 32'(i * 4);
            check(rlog[i] == ea_s, sh ? "R4" : "R3", "read addr", rlog[i], ea_s);
            check(wlog_a[i] == ea_d, dh ? "R4" : "R3", "write addr", wlog_a[i], ea_d);
            check(wlog_d[i] == memf(ea_s), "R2", "write data", wlog_d[i], memf(ea_s));
        end
        check(chan_active === 1'b0 && chan_frozen === 1'b0, "R5", "idle after done",
              {chan_active, chan_frozen}, 0);
        check(err_flags === 3'b000, "R5", "no error after done", err_flags, 0);
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(chan_active === 1'b0 && chan_frozen === 1'b0 && rd_req === 1'b0
              && wr_req === 1'b0 && err_flags === 3'b000, "R1", "reset state",
              {chan_active, chan_frozen, rd_req, wr_req, err_flags}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed: fill from one source, then stream into one destination
        run_xfer(32'h0000_1000, 32'h0000_8000, 6, 1'b1, 1'b0, 1'b0);
        run_xfer(32'h0000_2000, 32'h0000_9000, 5, 1'b0, 1'b1, 1'b0);
        run_xfer(32'h0000_3000, 32'h0000_A000, 1, 1'b0, 1'b0, 1'b0);
        // R10 load during a transfer
        run_xfer(32'h0000_4000, 32'h0000_B000, 8, 1'b0, 1'b0, 1'b1);

        // random transfers
        for (int k = 0; k < 20; k++) begin
            run_xfer({$urandom_range(32'hFFFF), 2'b00} & 32'hFFFF_FFFC,
                     {$urandom_range(32'hFFFF), 2'b00} & 32'hFFFF_FFFC,
                     int'($urandom_range(12, 1)), 1'($urandom_range(1)),
                     1'($urandom_range(1)), 1'b0);
        end

        // R6 read error on beat 2
        rd_err_beat = 2; nr = 0; nw = 0;
        load(32'h0000_5000, 32'h0000_C000, 16'd24, 1'b0, 1'b0);
        wait_end();
        rd_err_beat = -1;
        @(negedge clk);
        check(chan_frozen === 1'b1 && chan_active === 1'b1, "R6", "frozen after read error",
              {chan_frozen, chan_active}, 2'b11);
        check(err_flags === 3'b001, "R6", "read error bit", err_flags, 3'b001);
        check(nw == 2, "R6", "writes before error", 64'(nw), 2);
        // R10 load while frozen, R7 clear errors does not restart
        load(32'h0000_6000, 32'h0000_D000, 16'd8, 1'b0, 1'b0);
        reg_write(1'b0, 3'b111);
        repeat (10) @(negedge clk);
        check(nr == 2 && nw == 2, "R10", "no traffic while frozen", 64'(nr + nw), 4);
        check(err_flags === 3'b000, "R7", "error bits cleared", err_flags, 0);
        check(chan_frozen === 1'b1 && chan_active === 1'b1, "R7", "still frozen after clear",
              {chan_frozen, chan_active}, 2'b11);
        reg_write(1'b1, 3'b001);
        check(chan_frozen === 1'b0 && chan_active === 1'b0, "R8", "idle after restart",
              {chan_frozen, chan_active}, 0);

        // R6 write error on beat 1, R8 restart keeps error bit
        wr_err_beat = 1; nr = 0; nw = 0;
        load(32'h0000_7000, 32'h0000_E000, 16'd16, 1'b0, 1'b0);
        wait_end();
        wr_err_beat = -1;
        @(negedge clk);
        check(chan_frozen === 1'b1 && err_flags === 3'b010, "R6", "frozen after write error",
              {chan_frozen, err_flags}, {1'b1, 3'b010});
        check(nw == 1 && nr == 2, "R6", "traffic before write error", 64'(nw * 16 + nr), 18);
        reg_write(1'b1, 3'b001);
        check(chan_frozen === 1'b0 && chan_active === 1'b0 && err_flags === 3'b010, "R8",
              "restart keeps error flags", {chan_frozen, chan_active, err_flags}, 3'b010);
        reg_write(1'b0, 3'b010);
        run_xfer(32'h0000_0100, 32'h0000_0200, 3, 1'b0, 1'b0, 1'b0);

        // R9 zero-size descriptor
        nr = 0; nw = 0;
        load(32'h0000_0400, 32'h0000_0800, 16'd0, 1'b0, 1'b0);
        check(err_flags === 3'b100, "R9", "zero-size bit", err_flags, 3'b100);
        load(32'h0000_0400, 32'h0000_0800, 16'd8, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check(chan_active === 1'b1 && chan_frozen === 1'b0, "R9", "stuck active, not frozen",
              {chan_active, chan_frozen}, 2'b10);
        check(nr == 0 && nw == 0, "R9", "no requests when stuck", 64'(nr + nw), 0);
        reg_write(1'b1, 3'b001);
        reg_write(1'b0, 3'b100);
        check(chan_active === 1'b0 && err_flags === 3'b000, "R8", "restart from stuck",
              {chan_active, err_flags}, 0);
        run_xfer(32'h0000_0500, 32'h0000_0900, 4, 1'b1, 1'b1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule